// File: doc/BRIEF.md
# Shared Constant-Multiplier Table Loader

This controller reloads the coefficient of one lookup-table constant multiplier. Up to eight such multipliers hang on one shared load bus. A processor writes a 12-bit signed constant and a 3-bit target number while the controller is idle. The controller then runs a fixed 24-cycle sequence. On every cycle of that sequence it drives one 16-bit partial-product entry, the target number and two fill strobes.

Each multiplier keeps three 16-deep shift-register tables. Two of them serve the low input nibbles and are read as unsigned indices. The third serves the top nibble, which is read as two's complement. An entry shifted in first ends up at index 15. The controller therefore emits the products in three phases:
- fifteen down to eight times the constant, with only the unsigned strobe set;
- minus one down to minus eight times the constant, with only the signed strobe set;
- seven down to zero times the constant, with both strobes set.

No multiplier is used. Each phase start is formed from shifts, and each following entry subtracts the constant once.

Top module: `coef_loader_ctrl`

## Requirements
- R1: Bus layout, with bit 0 as the least significant bit: bits 20:5 carry the entry, bits 4:2 carry the target number, bit 1 is the unsigned-table strobe and bit 0 is the signed-table strobe. Bit 21 is always 0.
- R2: A write seen on a clock edge while idle starts a sequence. `busy` rises after that edge and stays high for exactly 24 cycles.
- R3: In sequence cycles 0 to 7 the entry is (15−n)·K, for n = 0..7, with strobes = 2'b10 (bit 1 = unsigned strobe set, bit 0 = signed strobe clear).
- R4: In sequence cycles 8 to 15 the entry is −(n−7)·K, which runs from −1·K to −8·K, with strobes = 2'b01 (only the signed strobe set).
- R5: In sequence cycles 16 to 23 the entry is (23−n)·K, which runs from 7·K to 0, with strobes = 2'b11.
- R6: Every entry is the exact product, sign-extended to 16 bits. This includes K = −2048 and K = 2047. Within a phase, each entry equals the previous entry minus K.
- R7: Throughout a sequence, the address field holds the target number that was captured with the write.
- R8: A write while `busy` is high is ignored. The running sequence keeps its constant and target, and no extra sequence follows.
- R9: While idle, the whole bus is zero: both strobes low, data field zero and address field zero.
- R10: A synchronous active-high reset aborts any sequence. After the reset edge, `busy` is 0 and the bus is zero.
- R11: A write in the first idle cycle after a sequence starts a new sequence with no gap.
- R12: After a full sequence, a modelled multiplier whose number matches the target holds i·K at index i of each unsigned table. Its signed table holds i·K for i < 8 and (i−16)·K for i ≥ 8. The other multipliers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe for constant and target |
| wr_coef | input | 12 | Signed constant to load |
| wr_target | input | 3 | Number of the multiplier to reload |
| busy | output | 1 | High during the 24-cycle sequence |
| load_bus | output | 22 | Shared load bus: entry, address and two strobes |

## Verification
On every cycle, the assertions check the following:
- the strobe pattern of each phase, tracked by a cycle counter in the checker;
- the one-constant step between neighbouring entries;
- the 15·K first entry and the 24-cycle busy length;
- the zero idle bus and the held address;
- the fact that a write while busy leaves the captured constant and target alone.

Only the bench scenarios can show the rest:
- that the shift-in order actually leaves every modelled table entry at the right index for its nibble;
- that the extreme constants stay exact;
- that a reset in mid-sequence or a write in the first idle cycle behaves as required.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;

  // Sequence phase: which group of tables is being filled.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_UHIGH = 2'd1,
    PH_SNEG  = 2'd2,
    PH_BOTH  = 2'd3
  } phase_e;

  // Fixed bit positions of the bus fields that every multiplier decodes.
  localparam int STB_SIGNED_BIT   = 0;
  localparam int STB_UNSIGNED_BIT = 1;
  localparam int ADDR_LSB         = 2;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_UHIGH: return PH_SNEG;
      PH_SNEG:  return PH_BOTH;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/coef_seq_ctrl.sv
module coef_seq_ctrl
  import coef_loader_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase,
  output logic   busy,
  output logic   phase_end,
  output logic   seq_end
);
  localparam int HALF  = DEPTH / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] sub_cnt;

  assign busy      = (phase != PH_IDLE);
  assign phase_end = busy && (sub_cnt == LAST);
  assign seq_end   = phase_end && (phase == PH_BOTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      sub_cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        phase   <= PH_UHIGH;
        sub_cnt <= '0;
      end
    end else if (phase_end) begin
      phase   <= next_phase(phase);
      sub_cnt <= '0;
    end else begin
      sub_cnt <= sub_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/coef_entry_gen.sv
module coef_entry_gen
  import coef_loader_pkg::*;
#(
  parameter int COEF_W  = 12,
  parameter int ENTRY_W = 16,
  parameter int DEPTH   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [COEF_W-1:0]  coef_in,
  input  phase_e                    phase,
  input  logic                      phase_end,
  output logic signed [COEF_W-1:0]  coef_q,
  output logic signed [ENTRY_W-1:0] entry
);
  localparam int LOG2D = $clog2(DEPTH);

  // Sign-extend the constant to the entry width.
  function automatic logic signed [ENTRY_W-1:0] widen(input logic signed [COEF_W-1:0] k);
    return {{(ENTRY_W-COEF_W){k[COEF_W-1]}}, k};
  endfunction

  // (2^sh - 1) * k, built from a shift and a subtract.
  function automatic logic signed [ENTRY_W-1:0] pow2m1_times(input logic signed [COEF_W-1:0] k,
                                                             input int sh);
    return (widen(k) <<< sh) - widen(k);
  endfunction

  logic signed [ENTRY_W-1:0] k_wide;
  assign k_wide = widen(coef_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q <= '0;
      entry  <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        coef_q <= coef_in;
        entry  <= pow2m1_times(coef_in, LOG2D);
      end
    end else if (phase_end) begin
      case (phase)
        PH_UHIGH: entry <= -k_wide;
        PH_SNEG:  entry <= pow2m1_times(coef_q, LOG2D - 1);
        default:  entry <= '0;
      endcase
    end else begin
      entry <= entry - k_wide;
    end
  end

endmodule

// File: rtl/coef_bus_pack.sv
module coef_bus_pack
  import coef_loader_pkg::*;
#(
  parameter int ENTRY_W = 16,
  parameter int ID_W    = 3,
  parameter int BUS_W   = 22
) (
  input  phase_e              phase,
  input  logic [ENTRY_W-1:0]  entry,
  input  logic [ID_W-1:0]     target,
  output logic [BUS_W-1:0]    bus
);
  localparam int DATA_LSB = ADDR_LSB + ID_W;

  always_comb begin
    bus = '0;
    if (phase != PH_IDLE) begin
      bus[DATA_LSB +: ENTRY_W]   = entry;
      bus[ADDR_LSB +: ID_W]      = target;
      bus[STB_UNSIGNED_BIT]      = (phase == PH_UHIGH) || (phase == PH_BOTH);
      bus[STB_SIGNED_BIT]        = (phase == PH_SNEG)  || (phase == PH_BOTH);
    end
  end

endmodule

// File: rtl/coef_loader_ctrl.sv
module coef_loader_ctrl
  import coef_loader_pkg::*;
#(
  parameter int COEF_W  = 12,
  parameter int ENTRY_W = 16,
  parameter int ID_W    = 3,
  parameter int DEPTH   = 16,
  localparam int BUS_W  = ADDR_LSB + ID_W + ENTRY_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [COEF_W-1:0] wr_coef,
  input  logic [ID_W-1:0]   wr_target,
  output logic              busy,
  output logic [BUS_W-1:0]  load_bus
);
  // Named internal events, brought out for the checker.
  phase_e                    phase;
  logic                      start_acc;
  logic                      phase_end;
  logic                      seq_end;
  logic signed [COEF_W-1:0]  coef_q;
  logic signed [ENTRY_W-1:0] entry;
  logic [ID_W-1:0]           target_q;

  assign start_acc = wr_en && !busy;

  coef_seq_ctrl #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .start(start_acc), .phase(phase),
    .busy(busy), .phase_end(phase_end), .seq_end(seq_end)
  );

  coef_entry_gen #(.COEF_W(COEF_W), .ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_gen (
    .clk(clk), .rst(rst), .start(start_acc), .coef_in(wr_coef),
    .phase(phase), .phase_end(phase_end), .coef_q(coef_q), .entry(entry)
  );

  always_ff @(posedge clk) begin
    if (rst)            target_q <= '0;
    else if (start_acc) target_q <= wr_target;
  end

  coef_bus_pack #(.ENTRY_W(ENTRY_W), .ID_W(ID_W), .BUS_W(BUS_W)) u_pack (
    .phase(phase), .entry(entry), .target(target_q), .bus(load_bus)
  );

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int COEF_W  = 12,
  parameter int ENTRY_W = 16,
  parameter int ID_W    = 3,
  parameter int DEPTH   = 16,
  parameter int BUS_W   = 22
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     busy,
  input logic [BUS_W-1:0]         load_bus,
  input logic signed [COEF_W-1:0] coef_q,
  input logic [ID_W-1:0]          target_q
);
  localparam int HALF = DEPTH / 2;
  localparam int SEQ  = 3 * HALF;

  int unsigned cyc;
  always_ff @(posedge clk) begin
    if (rst)       cyc <= 0;
    else if (busy) cyc <= cyc + 1;
    else           cyc <= 0;
  end

  logic signed [ENTRY_W-1:0] ent;
  logic signed [ENTRY_W-1:0] kx;
  assign ent = load_bus[2+ID_W +: ENTRY_W];
  assign kx  = ENTRY_W'(coef_q);

  assert_spare_zero_R1: assert property (@(posedge clk) disable iff (rst)
    load_bus[BUS_W-1] == 1'b0);
  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> cyc < SEQ);
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(cyc) == SEQ - 1);
  assert_first_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ent == ENTRY_W'(kx * (DEPTH - 1)));
  assert_strobe_uhigh_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc < HALF) |-> load_bus[1:0] == 2'b10);
  assert_strobe_sneg_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc >= HALF && cyc < 2*HALF) |-> load_bus[1:0] == 2'b01);
  assert_strobe_both_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc >= 2*HALF) |-> load_bus[1:0] == 2'b11);
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && cyc != HALF && cyc != 2*HALF) |-> ent == $past(ent) - kx);
  assert_addr_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> load_bus[2 +: ID_W] == target_q);
  assert_ignore_write_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> ($stable(coef_q) && $stable(target_q)));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> load_bus == '0);
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!busy && load_bus == '0));

endmodule

bind coef_loader_ctrl coef_loader_chk #(
  .COEF_W(COEF_W), .ENTRY_W(ENTRY_W), .ID_W(ID_W), .DEPTH(DEPTH), .BUS_W(BUS_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .load_bus(load_bus),
  .coef_q(coef_q), .target_q(target_q)
);

// File: tb/coef_loader_ctrl_tb.sv
`timescale 1ns / 1ps
module coef_loader_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_coef = '0;
  logic [2:0]  wr_target = '0;
  logic        busy;
  logic [21:0] load_bus;

  int n_cmp = 0;
  int n_bad = 0;
  logic [21:0] sb_q[$];

  // 125 MHz clock.
  always #4 clk = ~clk;

  coef_loader_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_coef(wr_coef),
    .wr_target(wr_target), .busy(busy), .load_bus(load_bus)
  );

  // Behavioural model of eight multipliers' shift-register tables.
  logic [15:0] tab_lo [8][16];
  logic [15:0] tab_mid[8][16];
  logic [15:0] tab_top[8][16];

  always @(posedge clk) begin
    for (int id = 0; id < 8; id++) begin
      if (load_bus[4:2] == 3'(id)) begin
        if (load_bus[1]) begin
          for (int i = 15; i > 0; i--) begin
            tab_lo[id][i]  <= tab_lo[id][i-1];
            tab_mid[id][i] <= tab_mid[id][i-1];
          end
          tab_lo[id][0]  <= load_bus[20:5];
          tab_mid[id][0] <= load_bus[20:5];
        end
        if (load_bus[0]) begin
          for (int i = 15; i > 0; i--) tab_top[id][i] <= tab_top[id][i-1];
          tab_top[id][0] <= load_bus[20:5];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] prod(input int k, input int idx);
    return 16'(k * idx);
  endfunction

  // Driver: issue a write at the current negedge and push the expected bus words.
  task automatic issue(input int k, input int id);
    wr_coef   = 12'(k);
    wr_target = 3'(id);
    wr_en     = 1'b1;
    for (int n = 0; n < 24; n++) begin
      int idx;
      logic [1:0] stb;
      if (n < 8)       begin idx = 15 - n; stb = 2'b10; end
      else if (n < 16) begin idx = 7 - n;  stb = 2'b01; end
      else             begin idx = 23 - n; stb = 2'b11; end
      sb_q.push_back({1'b0, prod(k, idx), 3'(id), stb});
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: compare every busy cycle against the scoreboard.
  always @(negedge clk) begin
    if (!rst && busy) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 busy beyond 24 cycles", {10'b0, load_bus}, 32'h0);
      end else begin
        logic [21:0] e;
        e = sb_q.pop_front();
        check(load_bus == e, "R1/R3/R4/R5/R6/R7 bus word", {10'b0, load_bus}, {10'b0, e});
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic end_of_seq(input string tag);
    check(sb_q.size() == 0, {tag, " R2 sequence length"}, sb_q.size(), 0);
    check(load_bus == '0, "R9 idle bus zero", {10'b0, load_bus}, 0);
  endtask

  task automatic check_tables(input int k, input int id);
    for (int i = 0; i < 16; i++) begin
      check(tab_lo[id][i]  == prod(k, i), "R12 low table",  tab_lo[id][i],  prod(k, i));
      check(tab_mid[id][i] == prod(k, i), "R12 mid table",  tab_mid[id][i], prod(k, i));
      check(tab_top[id][i] == prod(k, (i < 8) ? i : i - 16), "R12 top table",
            tab_top[id][i], prod(k, (i < 8) ? i : i - 16));
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int id = 0; id < 8; id++)
      for (int i = 0; i < 16; i++) begin
        tab_lo[id][i] = '0; tab_mid[id][i] = '0; tab_top[id][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R10 reset busy", busy, 0);
    check(load_bus == '0, "R9 reset bus zero", {10'b0, load_bus}, 0);

    // Plain constant, target 2.
    issue(1, 2);
    wait_idle();
    end_of_seq("k=1");
    check_tables(1, 2);
    check(tab_lo[3][15] == 16'h0, "R12 other multiplier untouched", tab_lo[3][15], 0);

    // Most negative constant.
    @(negedge clk);
    issue(-2048, 5);
    wait_idle();
    end_of_seq("k=-2048");
    check_tables(-2048, 5);

    // Most positive constant, then a write while busy (R8).
    @(negedge clk);
    issue(2047, 0);
    repeat (6) @(negedge clk);
    wr_coef = 12'h123; wr_target = 3'd7; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    end_of_seq("k=2047");
    check_tables(2047, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 no extra sequence", busy, 0);
    check(tab_lo[7][15] == 16'h0, "R8 ignored target untouched", tab_lo[7][15], 0);

    // Back-to-back: write in the first idle cycle (R11).
    issue(-1443, 4);
    wait_idle();
    end_of_seq("k=-1443");
    issue(93, 6);
    check(busy == 1'b1, "R11 back-to-back start", busy, 1);
    wait_idle();
    end_of_seq("R11 k=93");
    check_tables(-1443, 4);
    check_tables(93, 6);

    // Reset in mid-sequence (R10).
    @(negedge clk);
    issue(77, 1);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sb_q.delete();
    check(busy == 1'b0, "R10 abort busy", busy, 0);
    check(load_bus == '0, "R10 abort bus zero", {10'b0, load_bus}, 0);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R10 stays idle", busy, 0);

    // Zero constant after reset.
    issue(0, 3);
    wait_idle();
    end_of_seq("k=0");
    check_tables(0, 3);

    finish_run();
  end

endmodule